// File: doc/BRIEF.md
# Byte/Pair Register File

This block is the general-purpose register storage of a small 8-bit core: thirty-two byte-wide registers behind two read ports and one write port. Neighbouring registers with indices 2k and 2k+1 can also be used together as one 16-bit word. The byte at the even index is the low half and the byte at the odd index is the high half. Each cycle a two-bit mode input picks one of four access schemes. The mode sets how wide each read is, whether the second read port is in use, and whether the write stores one byte or a pair.

Both read ports are combinational. A write commits on the rising clock edge when `wr_en` is high. A read of a register that is being written in the same cycle returns the value it held before that edge, because there is no internal bypass. A 16-bit access at an odd index is rejected: `pair_err` rises in the same cycle and the write in that cycle is dropped.

Top module: `pairreg_file`

## Requirements
- R1: An active-low `rst_n` clears all 32 registers to zero, and afterwards every read returns zero.
- R2: Mode 0 (one byte read, byte write) drives `rdata_a[7:0]` with register `idx_a` and drives `rdata_a[15:8]` and `rdata_b` with zero. With `wr_en` high, the rising edge stores `wdata[7:0]` into register `idx_w`.
- R3: Mode 1 (two byte reads, byte write) drives `rdata_a[7:0]` with register `idx_a`, `rdata_a[15:8]` with zero and `rdata_b` with register `idx_b`. The write behaves as in R2.
- R4: Mode 2 (two byte reads, pair write) reads as in R3. With `wr_en` high and `idx_w` even, the rising edge stores `wdata[7:0]` into register `idx_w` and `wdata[15:8]` into register `idx_w`+1.
- R5: Mode 3 (pair read, pair write) drives `rdata_a` with {register `idx_a`+1, register `idx_a`} when `idx_a` is even, and drives `rdata_b` with zero. The write behaves as in R4.
- R6: The read outputs follow the index inputs within the same cycle, with no clock edge in between.
- R7: A read of a register that is written in the same cycle returns the old value. The new value appears after the edge.
- R8: In modes 2 and 3, an odd `idx_w` with `wr_en` high raises `pair_err` in that cycle, and no register changes.
- R9: In mode 3, an odd `idx_a` raises `pair_err` and forces `rdata_a` to zero. Any write in that cycle is dropped.
- R10: With `wr_en` low no register changes, whatever `wdata` and `idx_w` carry.
- R11: Modes 0 and 1 never raise `pair_err`, whatever the parity of the indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Access scheme: 0 byte/byte, 1 two bytes/byte, 2 two bytes/pair, 3 pair/pair |
| idx_a | input | 5 | Index for read port A (even for a pair read) |
| idx_b | input | 5 | Index for read port B |
| idx_w | input | 5 | Write index (even for a pair write) |
| wr_en | input | 1 | Write enable |
| wdata | input | 16 | Write data; the low byte is used for byte writes |
| rdata_a | output | 16 | Read port A data; the upper byte is zero for byte reads |
| rdata_b | output | 8 | Read port B data; zero in modes 0 and 3 |
| pair_err | output | 1 | A 16-bit access used an odd index |

## Verification
The bound checker watches the register array on every cycle. It checks that byte and pair writes land at the addressed indices one edge later, and that the array holds still when `wr_en` is low or `pair_err` is raised. It also checks that odd-index pair accesses flag the error, that byte modes never do, and that port B and the pair read match the stored bytes. The bench's scenarios are needed for the rest. They show the old-value return when a register is read and written in the same cycle, and the zero state after a second reset following real writes. They also cover the sequences where error cycles sit between good writes, and a long pseudo-random run against a reference array model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    MODE_B1   = 2'd0,
    MODE_B2   = 2'd1,
    MODE_B2W  = 2'd2,
    MODE_W1   = 2'd3
  } rf_mode_e;
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import rf_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  rf_mode_e         mode_i,
  input  logic [IDX_W-1:0] idx_a_i,
  input  logic [IDX_W-1:0] idx_w_i,
  input  logic             wr_en_i,
  output logic             rd_a_wide_o,
  output logic             rd_b_used_o,
  output logic             wr_wide_o,
  output logic             pair_err_o,
  output logic             wr_commit_o
);
  logic rd_err, wr_err;

  always_comb begin
    rd_a_wide_o = (mode_i == MODE_W1);
    rd_b_used_o = (mode_i == MODE_B2) || (mode_i == MODE_B2W);
    wr_wide_o   = (mode_i == MODE_B2W) || (mode_i == MODE_W1);
    rd_err      = rd_a_wide_o && idx_a_i[0];
    wr_err      = wr_wide_o && wr_en_i && idx_w_i[0];
    pair_err_o  = rd_err || wr_err;
    wr_commit_o = wr_en_i && !pair_err_o;
  end
endmodule

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              wr_commit_i,
  input  logic              wr_wide_i,
  input  logic [IDX_W-1:0]  idx_w_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  output logic [NUM_REGS-1:0] reg_en_o,
  output logic [DATA_W-1:0] reg_d_o [NUM_REGS]
);
  logic [IDX_W-1:0] idx_hi;
  assign idx_hi = {idx_w_i[IDX_W-1:1], 1'b1};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hit_lo, hit_hi;
    assign hit_lo = (idx_w_i == IDX_W'(i));
    assign hit_hi = wr_wide_i && (idx_hi == IDX_W'(i));
    assign reg_en_o[i] = wr_commit_i && (hit_lo || hit_hi);
    if (i % 2 == 1) begin : g_odd
      assign reg_d_o[i] = wr_wide_i ? wdata_i[2*DATA_W-1:DATA_W] : wdata_i[DATA_W-1:0];
    end else begin : g_even
      assign reg_d_o[i] = wdata_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] reg_en_i,
  input  logic [DATA_W-1:0]   reg_d_i [NUM_REGS],
  output logic [DATA_W-1:0]   reg_q_o [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q_o[i] <= '0;
      end else if (reg_en_i[i]) begin
        reg_q_o[i] <= reg_d_i[i];
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned DATA_W    = 8,
  parameter bit          WIDE_CAP  = 1'b1,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned OUT_W    = WIDE_CAP ? 2*DATA_W : DATA_W
) (
  input  logic [DATA_W-1:0] regs_i [NUM_REGS],
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              en_i,
  input  logic              wide_i,
  output logic [OUT_W-1:0]  data_o
);
  logic [DATA_W-1:0] lo, hi;

  always_comb begin
    lo = regs_i[idx_i];
    hi = regs_i[{idx_i[IDX_W-1:1], 1'b1}];
    data_o = '0;
    if (en_i) begin
      if (WIDE_CAP && wide_i) begin
        if (!idx_i[0]) data_o = OUT_W'({hi, lo});
      end else begin
        data_o[DATA_W-1:0] = lo;
      end
    end
  end
endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [IDX_W-1:0]    idx_a,
  input  logic [IDX_W-1:0]    idx_b,
  input  logic [IDX_W-1:0]    idx_w,
  input  logic                wr_en,
  input  logic [2*DATA_W-1:0] wdata,
  output logic [2*DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0]   rdata_b,
  output logic                pair_err
);
  rf_mode_e            mode_e;
  logic                rd_a_wide, rd_b_used, wr_wide, wr_commit;
  logic [NUM_REGS-1:0] reg_en;
  logic [DATA_W-1:0]   reg_d [NUM_REGS];
  logic [DATA_W-1:0]   rf_q  [NUM_REGS];

  assign mode_e = rf_mode_e'(mode);

  rf_mode_decode #(.IDX_W(IDX_W)) u_dec (
    .mode_i      (mode_e),
    .idx_a_i     (idx_a),
    .idx_w_i     (idx_w),
    .wr_en_i     (wr_en),
    .rd_a_wide_o (rd_a_wide),
    .rd_b_used_o (rd_b_used),
    .wr_wide_o   (wr_wide),
    .pair_err_o  (pair_err),
    .wr_commit_o (wr_commit)
  );

  rf_write_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_wdec (
    .wr_commit_i (wr_commit),
    .wr_wide_i   (wr_wide),
    .idx_w_i     (idx_w),
    .wdata_i     (wdata),
    .reg_en_o    (reg_en),
    .reg_d_o     (reg_d)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_en_i (reg_en),
    .reg_d_i  (reg_d),
    .reg_q_o  (rf_q)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WIDE_CAP(1'b1)) u_rd_a (
    .regs_i (rf_q),
    .idx_i  (idx_a),
    .en_i   (1'b1),
    .wide_i (rd_a_wide),
    .data_o (rdata_a)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .WIDE_CAP(1'b0)) u_rd_b (
    .regs_i (rf_q),
    .idx_i  (idx_b),
    .en_i   (rd_b_used),
    .wide_i (1'b0),
    .data_o (rdata_b)
  );
endmodule

// File: rtl/pairreg_file_chk.sv
module pairreg_file_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic [IDX_W-1:0]    idx_a,
  input logic [IDX_W-1:0]    idx_b,
  input logic [IDX_W-1:0]    idx_w,
  input logic                wr_en,
  input logic [2*DATA_W-1:0] wdata,
  input logic [2*DATA_W-1:0] rdata_a,
  input logic [DATA_W-1:0]   rdata_b,
  input logic                pair_err,
  input logic [DATA_W-1:0]   q [NUM_REGS]
);
  logic [NUM_REGS*DATA_W-1:0] q_flat;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) q_flat[i*DATA_W +: DATA_W] = q[i];
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_flat == '0));

  a_r2_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode[1]) |=> (q[$past(idx_w)] == $past(wdata[DATA_W-1:0])));

  a_r3_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (rdata_b == q[idx_b]));

  a_r4_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode[1] && !idx_w[0] && !(mode == 2'd3 && idx_a[0])) |=>
      (q[$past(idx_w)] == $past(wdata[DATA_W-1:0])) &&
      (q[{$past(idx_w[IDX_W-1:1]), 1'b1}] == $past(wdata[2*DATA_W-1:DATA_W])));

  a_r5_pair_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !idx_a[0]) |->
      (rdata_a == {q[{idx_a[IDX_W-1:1], 1'b1}], q[idx_a]}) && (rdata_b == '0));

  a_r8_odd_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && wr_en && idx_w[0]) |-> pair_err);

  a_r8_err_holds_file: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |=> $stable(q_flat));

  a_r9_odd_pair_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && idx_a[0]) |-> (pair_err && rdata_a == '0));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_flat));

  a_r11_byte_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> !pair_err);
endmodule

bind pairreg_file pairreg_file_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .idx_a(idx_a), .idx_b(idx_b),
  .idx_w(idx_w), .wr_en(wr_en), .wdata(wdata), .rdata_a(rdata_a),
  .rdata_b(rdata_b), .pair_err(pair_err), .q(rf_q)
);

// File: tb/tb_pairreg_file.sv
module tb_pairreg_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [4:0]  idx_a, idx_b, idx_w;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata_a;
  logic [7:0]  rdata_b;
  logic        pair_err;

  always #2 clk = ~clk;

  pairreg_file dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .idx_a(idx_a), .idx_b(idx_b),
    .idx_w(idx_w), .wr_en(wr_en), .wdata(wdata), .rdata_a(rdata_a),
    .rdata_b(rdata_b), .pair_err(pair_err)
  );

  typedef struct {
    logic [15:0] a;
    logic [7:0]  b;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  model [32];
  int          checks = 0;
  int          errors = 0;
  bit          reported = 1'b0;
  bit          done = 1'b0;
  logic [31:0] lf = 32'h1ACE_5EED;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: compares outputs mid-cycle against queued expectations
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rdata_a !== e.a || rdata_b !== e.b || pair_err !== e.err) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h err=%b expected a=%h b=%h err=%b",
                 e.tag, rdata_a, rdata_b, pair_err, e.a, e.b, e.err);
      end
    end
  end

  // Driver: applies one cycle, queues the expected outputs, advances the model
  task automatic step(input logic [1:0] md, input logic [4:0] a, input logic [4:0] b,
                      input logic [4:0] w, input logic we, input logic [15:0] wd,
                      input string tag);
    exp_t e;
    logic err;
    @(negedge clk);
    mode = md; idx_a = a; idx_b = b; idx_w = w; wr_en = we; wdata = wd;
    err = (md == 2'd3 && a[0]) || (md[1] && we && w[0]);
    if (md == 2'd3) e.a = a[0] ? 16'h0 : {model[a | 5'd1], model[a]};
    else            e.a = {8'h00, model[a]};
    e.b   = (md == 2'd1 || md == 2'd2) ? model[b] : 8'h00;
    e.err = err;
    e.tag = tag;
    sb.push_back(e);
    if (we && !err) begin
      if (md[1]) begin
        model[w]         = wd[7:0];
        model[w | 5'd1]  = wd[15:8];
      end else begin
        model[w] = wd[7:0];
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; mode = 2'd0;
    foreach (model[i]) model[i] = 8'h00;
    @(negedge clk);
    @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 32; i += 2) step(2'd3, 5'(i), 5'd0, 5'd0, 1'b0, 16'h0, tag);
    for (int i = 0; i < 32; i++)    step(2'd1, 5'(i), 5'(31 - i), 5'd0, 1'b0, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; idx_a = '0; idx_b = '0; idx_w = '0;
    wr_en = 1'b0; wdata = '0;
    foreach (model[i]) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    read_all("R1 reset state");

    // R2 / R7 / R11: byte writes, reading the target in the same cycle
    for (int i = 0; i < 32; i++)
      step(2'd0, 5'(i), 5'd0, 5'(i), 1'b1, {8'hEE, 8'(i * 37 + 11)}, "R7 R2 R11 byte write");
    // R3 / R6: index sweep on both ports, one per cycle
    for (int i = 0; i < 32; i++)
      step(2'd1, 5'(i), 5'(i ^ 5'h15), 5'(31 - i), 1'b1, {8'h00, 8'(i * 5)}, "R3 R6 two reads");
    // R4: pair writes with concurrent byte reads
    for (int i = 0; i < 32; i += 2)
      step(2'd2, 5'(i + 1), 5'(i), 5'(i), 1'b1, 16'(i * 16'h0301 + 16'hA55A), "R4 pair write");
    // R5: pair read and pair write
    for (int i = 0; i < 32; i += 2)
      step(2'd3, 5'(30 - i), 5'(i), 5'(i), 1'b1, 16'(16'hC3C3 ^ (i * 16'h1111)), "R5 pair rw");
    step(2'd3, 5'd6, 5'd0, 5'd6, 1'b1, 16'h1234, "R7 R5 pair old value");
    step(2'd3, 5'd6, 5'd0, 5'd0, 1'b0, 16'h0, "R7 R5 pair new value");

    // R8: odd write index on pair writes
    step(2'd2, 5'd4, 5'd5, 5'd5, 1'b1, 16'hDEAD, "R8 odd pair write mode2");
    step(2'd3, 5'd4, 5'd0, 5'd9, 1'b1, 16'hBEEF, "R8 odd pair write mode3");
    read_all("R8 file unchanged");
    // R9: odd pair read, write with even index dropped
    step(2'd3, 5'd7, 5'd0, 5'd10, 1'b1, 16'hF00D, "R9 odd pair read");
    step(2'd3, 5'd10, 5'd0, 5'd0, 1'b0, 16'h0, "R9 write dropped");
    // R10: writes disabled
    for (int i = 0; i < 8; i++)
      step(2'(i % 4), 5'(i * 2), 5'(i), 5'(i * 4), 1'b0, 16'hFFFF, "R10 no write");
    read_all("R10 file unchanged");
    // R11: byte modes with odd indices
    step(2'd0, 5'd3, 5'd1, 5'd31, 1'b1, 16'h0077, "R11 byte odd");
    step(2'd1, 5'd31, 5'd3, 5'd1, 1'b1, 16'h0088, "R11 byte odd");

    // Mixed pseudo-random traffic
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[1:0], lf[6:2], lf[11:7], lf[16:12], lf[17], lf[31:16] ^ lf[15:0], "R2 R3 R4 R5 R8 R9 random");
    end

    // R1: reset after real traffic
    do_reset();
    read_all("R1 reset after writes");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule